// File: doc/BRIEF.md
# Serial Port FIFO Control and Status Register Block

This block is the software-visible register file of a FIFO-based serial port. It sits on a simple synchronous bus with an address, a write enable, write data, a read enable and read data. Read data is registered and appears on the cycle after the read request. The block stores the mode, bit-rate, control, FIFO control and port settings. It also keeps a set of status flags, which the receive logic sets with one-cycle pulses and which software clears by writing zero to each flag's bit.

A write to the transmit data offset is posted at once to a one-cycle transmit strobe together with the byte. Transmission is treated as finishing immediately. For that reason, while the transmitter is enabled, each read of the status register marks the transmitter empty and the transmission ended again. A read of the receive data offset returns the byte that the external receive FIFO presents and sends a pop strobe back to it. The receive count offset returns the fill level that the FIFO reports. The block drives two interrupt lines. The transmit line follows a control bit. The receive line is raised by a receive-full pulse when the receive interrupt is enabled.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset the status register reads 0x60 (transmit-end and transmit-empty set, all other flags clear), the bit-rate register reads 0xFF, the control register reads 0x20, and the mode, port and FIFO control registers read 0. Both interrupt outputs are low.
- R2: Writes are masked as follows: mode (offset 0x00) with 0x7B, control (0x08) with 0xFA, port (0x20) with 0xF3. Bit rate (0x04, 8 bits) and FIFO control (0x18, 16 bits) store the written value unchanged.
- R3: A status read (offset 0x10) returns transmit-end in bit 6, transmit-empty in bit 5, break in bit 4, receive-full in bit 1 and data-ready in bit 0, with the other bits 0. If control bit 5 (transmit enable) is 1, the read then sets transmit-empty and transmit-end.
- R4: A status write clears each flag whose bit is written as 0 and leaves unchanged each flag whose bit is written as 1.
- R5: A control write with bit 5 at 0 sets transmit-end. The transmit interrupt output equals control bit 7 from the cycle after the write.
- R6: A write to offset 0x0C raises tx_strobe for exactly one cycle, with tx_byte equal to the low 8 bits of the written data, and clears transmit-empty.
- R7: Pulses on rdf_set, dr_set and brk_set set receive-full, data-ready and break. A pulse in the same cycle as a status write that clears the same flag leaves the flag set.
- R8: The receive interrupt rises one cycle after an rdf_set pulse while control bit 6 is 1. It falls after a status write with bit 1 or bit 0 at 0, or after a control write with bit 6 at 0.
- R9: A read of offset 0x14 returns rx_data_in and pulses rx_pop for one cycle, aligned with the returned data. A read of offset 0x1C returns rx_count_in and does not pulse rx_pop.
- R10: A read of any offset outside the map returns 0. All read data is valid on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_we | input | 1 | Write request |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_re |
| rx_data_in | input | 8 | Head byte presented by the receive FIFO |
| rx_count_in | input | 5 | Fill level reported by the receive FIFO |
| rx_pop | output | 1 | One-cycle pop strobe to the receive FIFO |
| rdf_set | input | 1 | Receive-full set pulse |
| dr_set | input | 1 | Data-ready set pulse |
| brk_set | input | 1 | Break set pulse |
| tx_strobe | output | 1 | One-cycle strobe for a posted transmit byte |
| tx_byte | output | 8 | Transmitted byte |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach from the ports is a set pulse landing in the same clock cycle as a status write that clears the same flag. The bench drives brk_set and a clearing write on the same falling edge, then reads the status back to confirm that the flag survived. A second difficult area is the read side effect on the transmit flags: transmit-empty must first be cleared by a data write, then observed clear, and then seen to reappear only on the read that follows while transmit is enabled, and not while it is disabled. Each way of dropping the receive interrupt is reached by first raising it with a receive-full pulse and then applying exactly one clearing action.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_RATE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TXD   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_FIFO  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_PORT  = 6'h20;

  localparam logic [BYTE_W-1:0] MASK_MODE = 8'h7B;
  localparam logic [BYTE_W-1:0] MASK_CTRL = 8'hFA;
  localparam logic [BYTE_W-1:0] MASK_PORT = 8'hF3;

  localparam logic [BYTE_W-1:0] RST_RATE = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_CTRL = 8'h20;

  // control bit positions
  localparam int CB_TXIE = 7;
  localparam int CB_RXIE = 6;
  localparam int CB_TXEN = 5;

  // status bit positions
  localparam int SB_TEND = 6;
  localparam int SB_TDE  = 5;
  localparam int SB_BRK  = 4;
  localparam int SB_RDF  = 1;
  localparam int SB_DR   = 0;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;
endpackage

// File: rtl/urf_cfg_regs.sv
module urf_cfg_regs
  import urf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [BW-1:0] mode_q,
  output logic [BW-1:0] rate_q,
  output logic [BW-1:0] ctrl_q,
  output logic [DW-1:0] fifo_q,
  output logic [BW-1:0] port_q
);
  logic [BW-1:0] wbyte;
  assign wbyte = wdata[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rate_q <= RST_RATE;
      ctrl_q <= RST_CTRL;
      fifo_q <= '0;
      port_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_MODE: mode_q <= wbyte & MASK_MODE;
        OFS_RATE: rate_q <= wbyte;
        OFS_CTRL: ctrl_q <= wbyte & MASK_CTRL;
        OFS_FIFO: fifo_q <= wdata;
        OFS_PORT: port_q <= wbyte & MASK_PORT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/urf_status_flags.sv
module urf_status_flags
  import urf_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stat_wr,
  input  logic          stat_rd,
  input  logic          ctrl_wr,
  input  logic          txd_wr,
  input  logic [BW-1:0] wbyte,
  input  logic          tx_en,
  input  logic          rx_ie,
  input  logic          rdf_set,
  input  logic          dr_set,
  input  logic          brk_set,
  output flags_t        flags_q,
  output logic          rx_irq_q
);
  flags_t nxt;
  logic   irq_nxt;

  always_comb begin
    nxt = flags_q;
    if (stat_wr) begin
      if (!wbyte[SB_TEND]) nxt.tend = 1'b0;
      if (!wbyte[SB_TDE])  nxt.tde  = 1'b0;
      if (!wbyte[SB_BRK])  nxt.brk  = 1'b0;
      if (!wbyte[SB_RDF])  nxt.rdf  = 1'b0;
      if (!wbyte[SB_DR])   nxt.dr   = 1'b0;
    end
    if (txd_wr) nxt.tde = 1'b0;
    if (ctrl_wr && !wbyte[CB_TXEN]) nxt.tend = 1'b0 | 1'b1;
    if (stat_rd && tx_en) begin
      nxt.tde  = 1'b1;
      nxt.tend = 1'b1;
    end
    // set pulses win over clearing writes
    if (rdf_set) nxt.rdf = 1'b1;
    if (dr_set)  nxt.dr  = 1'b1;
    if (brk_set) nxt.brk = 1'b1;
  end

  always_comb begin
    irq_nxt = rx_irq_q;
    if (stat_wr && (!wbyte[SB_RDF] || !wbyte[SB_DR])) irq_nxt = 1'b0;
    if (ctrl_wr && !wbyte[CB_RXIE]) irq_nxt = 1'b0;
    if (rdf_set && rx_ie) irq_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
      rx_irq_q <= 1'b0;
    end else begin
      flags_q  <= nxt;
      rx_irq_q <= irq_nxt;
    end
  end
endmodule

// File: rtl/urf_read_port.sv
module urf_read_port
  import urf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] mode_q,
  input  logic [BW-1:0] rate_q,
  input  logic [BW-1:0] ctrl_q,
  input  logic [DW-1:0] fifo_q,
  input  logic [BW-1:0] port_q,
  input  logic [BW-1:0] stat_img,
  input  logic [BW-1:0] rx_data,
  input  logic [CW-1:0] rx_count,
  output logic [DW-1:0] rdata_q,
  output logic          pop_q
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      OFS_MODE:  sel = DW'(mode_q);
      OFS_RATE:  sel = DW'(rate_q);
      OFS_CTRL:  sel = DW'(ctrl_q);
      OFS_STAT:  sel = DW'(stat_img);
      OFS_RXD:   sel = DW'(rx_data);
      OFS_FIFO:  sel = fifo_q;
      OFS_RXCNT: sel = DW'(rx_count);
      OFS_PORT:  sel = DW'(port_q);
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      pop_q   <= 1'b0;
    end else begin
      pop_q <= rd_en && (addr == OFS_RXD);
      if (rd_en) rdata_q <= sel;
      else       rdata_q <= '0;
    end
  end
endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import urf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic [BW-1:0] rx_data_in,
  input  logic [CW-1:0] rx_count_in,
  output logic          rx_pop,
  input  logic          rdf_set,
  input  logic          dr_set,
  input  logic          brk_set,
  output logic          tx_strobe,
  output logic [BW-1:0] tx_byte,
  output logic          tx_irq,
  output logic          rx_irq
);
  logic [BW-1:0] mode_q, rate_q, ctrl_q, port_q;
  logic [DW-1:0] fifo_q;
  flags_t        flags_q;
  logic [BW-1:0] stat_img;
  logic          stat_wr, stat_rd, ctrl_wr, txd_wr;

  assign stat_wr = bus_we && (bus_addr == OFS_STAT);
  assign stat_rd = bus_re && (bus_addr == OFS_STAT);
  assign ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
  assign txd_wr  = bus_we && (bus_addr == OFS_TXD);

  always_comb begin
    stat_img          = '0;
    stat_img[SB_TEND] = flags_q.tend;
    stat_img[SB_TDE]  = flags_q.tde;
    stat_img[SB_BRK]  = flags_q.brk;
    stat_img[SB_RDF]  = flags_q.rdf;
    stat_img[SB_DR]   = flags_q.dr;
  end

  urf_cfg_regs #(.AW(AW), .DW(DW), .BW(BW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .fifo_q(fifo_q),
    .port_q(port_q)
  );

  urf_status_flags #(.BW(BW)) u_flags (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_rd(stat_rd),
    .ctrl_wr(ctrl_wr), .txd_wr(txd_wr), .wbyte(bus_wdata[BW-1:0]),
    .tx_en(ctrl_q[CB_TXEN]), .rx_ie(ctrl_q[CB_RXIE]),
    .rdf_set(rdf_set), .dr_set(dr_set), .brk_set(brk_set),
    .flags_q(flags_q), .rx_irq_q(rx_irq)
  );

  urf_read_port #(.AW(AW), .DW(DW), .BW(BW), .CW(CW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_re), .addr(bus_addr),
    .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .fifo_q(fifo_q),
    .port_q(port_q), .stat_img(stat_img), .rx_data(rx_data_in),
    .rx_count(rx_count_in), .rdata_q(bus_rdata), .pop_q(rx_pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= txd_wr;
      if (txd_wr) tx_byte <= bus_wdata[BW-1:0];
    end
  end

  assign tx_irq = ctrl_q[CB_TXIE];
endmodule

// File: rtl/urf_checker.sv
module urf_checker
  import urf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          tx_strobe,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic          rdf_set,
  input logic          brk_set,
  input logic [BW-1:0] mode_q,
  input flags_t        flags_q
);
  // R6: strobe only follows a transmit data write
  a_r6_strobe_src: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> $past(bus_we && bus_addr == OFS_TXD));

  // R7: set pulses win
  a_r7_brk_set: assert property (@(posedge clk) disable iff (rst)
    brk_set |=> flags_q.brk);
  a_r7_rdf_set: assert property (@(posedge clk) disable iff (rst)
    rdf_set |=> flags_q.rdf);

  // R5: transmit interrupt follows written control bit 7
  a_r5_txi_follow: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_CTRL) |=> (tx_irq == $past(bus_wdata[CB_TXIE])));

  // R8: receive interrupt rises only after a receive-full pulse
  a_r8_rxi_source: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(rdf_set));

  // R2: mode register never holds masked-off bits
  a_r2_mode_mask: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MODE) |=> ((mode_q & ~MASK_MODE) == '0));

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr > OFS_PORT) |=> (bus_rdata == '0));
endmodule

bind uart_fifo_regs urf_checker #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_strobe(tx_strobe), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .rdf_set(rdf_set), .brk_set(brk_set), .mode_q(mode_q), .flags_q(flags_q)
);

// File: tb/tb_uart_fifo_regs.sv
`timescale 1ns/1ps
module tb_uart_fifo_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [7:0]  rx_data_in = '0;
  logic [4:0]  rx_count_in = '0;
  logic        rx_pop;
  logic        rdf_set = 1'b0, dr_set = 1'b0, brk_set = 1'b0;
  logic        tx_strobe;
  logic [7:0]  tx_byte;
  logic        tx_irq, rx_irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd_val;
  logic        rd_pop;

  always #4 clk = ~clk;

  uart_fifo_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_data_in(rx_data_in), .rx_count_in(rx_count_in), .rx_pop(rx_pop),
    .rdf_set(rdf_set), .dr_set(dr_set), .brk_set(brk_set),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // entry: {is_write, addr[5:0], data[15:0], req[7:0]}
  localparam int NV = 36;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 6'h00, 16'h0000, 8'd1},   // R1 mode
    {1'b0, 6'h04, 16'h00FF, 8'd1},   // R1 rate
    {1'b0, 6'h08, 16'h0020, 8'd1},   // R1 control
    {1'b0, 6'h18, 16'h0000, 8'd1},   // R1 fifo control
    {1'b0, 6'h20, 16'h0000, 8'd1},   // R1 port
    {1'b0, 6'h10, 16'h0060, 8'd1},   // R1 status
    {1'b1, 6'h00, 16'hFFFF, 8'd2},
    {1'b0, 6'h00, 16'h007B, 8'd2},   // R2 mode mask
    {1'b1, 6'h08, 16'hFFFF, 8'd2},
    {1'b0, 6'h08, 16'h00FA, 8'd2},   // R2 control mask
    {1'b1, 6'h20, 16'hFFFF, 8'd2},
    {1'b0, 6'h20, 16'h00F3, 8'd2},   // R2 port mask
    {1'b1, 6'h04, 16'h005A, 8'd2},
    {1'b0, 6'h04, 16'h005A, 8'd2},   // R2 rate
    {1'b1, 6'h18, 16'hABCD, 8'd2},
    {1'b0, 6'h18, 16'hABCD, 8'd2},   // R2 fifo control
    {1'b0, 6'h28, 16'h0000, 8'd10},  // R10
    {1'b0, 6'h3C, 16'h0000, 8'd10},  // R10
    {1'b1, 6'h0C, 16'h0041, 8'd6},
    {1'b0, 6'h10, 16'h0040, 8'd6},   // R6 tde cleared
    {1'b0, 6'h10, 16'h0060, 8'd3},   // R3 refilled by read
    {1'b1, 6'h08, 16'h0000, 8'd5},
    {1'b1, 6'h10, 16'h0000, 8'd4},
    {1'b0, 6'h10, 16'h0000, 8'd4},   // R4 all cleared
    {1'b0, 6'h10, 16'h0000, 8'd3},   // R3 no refill, tx disabled
    {1'b1, 6'h08, 16'h0000, 8'd5},
    {1'b0, 6'h10, 16'h0040, 8'd5},   // R5 tend set
    {1'b1, 6'h10, 16'h00BF, 8'd4},
    {1'b0, 6'h10, 16'h0000, 8'd4},   // R4 bit 6 cleared
    {1'b1, 6'h08, 16'h0000, 8'd5},
    {1'b1, 6'h10, 16'hFFFF, 8'd4},
    {1'b0, 6'h10, 16'h0040, 8'd4},   // R4 ones keep
    {1'b1, 6'h08, 16'h0020, 8'd5},
    {1'b1, 6'h10, 16'h0000, 8'd4},
    {1'b0, 6'h10, 16'h0000, 8'd4},   // R4
    {1'b0, 6'h10, 16'h0060, 8'd3}    // R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    rd_val = bus_rdata;
    rd_pop = rx_pop;
  endtask

  task automatic pulse_rdf();
    @(negedge clk); rdf_set = 1'b1;
    @(negedge clk); rdf_set = 1'b0;
  endtask

  task automatic pulse_dr();
    @(negedge clk); dr_set = 1'b1;
    @(negedge clk); dr_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 tx_irq", {15'd0, tx_irq}, 16'd0);
    chk("R1 rx_irq", {15'd0, rx_irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][30]) do_write(VEC[i][29:24], VEC[i][23:8]);
      else begin
        do_read(VEC[i][29:24]);
        chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), rd_val, VEC[i][23:8]);
      end
    end

    // R6 transmit strobe
    do_write(6'h0C, 16'h125C);
    chk("R6 strobe", {15'd0, tx_strobe}, 16'd1);
    chk("R6 byte", {8'd0, tx_byte}, 16'h005C);
    @(negedge clk);
    chk("R6 strobe one cycle", {15'd0, tx_strobe}, 16'd0);

    // R5 transmit interrupt follows control bit 7
    do_write(6'h08, 16'h00A0);
    chk("R5 txi high", {15'd0, tx_irq}, 16'd1);
    do_write(6'h08, 16'h0020);
    chk("R5 txi low", {15'd0, tx_irq}, 16'd0);

    // R8 receive interrupt, cleared by RDF bit write
    do_write(6'h08, 16'h0060);
    pulse_rdf();
    chk("R8 rxi raised", {15'd0, rx_irq}, 16'd1);
    do_read(6'h10);
    chk("R7 rdf set", rd_val & 16'h0002, 16'h0002);
    do_write(6'h10, 16'h00FD);
    chk("R8 rxi cleared by rdf write", {15'd0, rx_irq}, 16'd0);
    do_read(6'h10);
    chk("R4 rdf cleared", rd_val & 16'h0002, 16'h0000);

    // R7 data-ready, R8 cleared by DR bit write
    pulse_dr();
    do_read(6'h10);
    chk("R7 dr set", rd_val & 16'h0001, 16'h0001);
    pulse_rdf();
    chk("R8 rxi raised again", {15'd0, rx_irq}, 16'd1);
    do_write(6'h10, 16'h00FE);
    chk("R8 rxi cleared by dr write", {15'd0, rx_irq}, 16'd0);
    do_read(6'h10);
    chk("R4 dr cleared rdf kept", rd_val & 16'h0003, 16'h0002);

    // R8 cleared by control write with bit 6 low
    pulse_rdf();
    chk("R8 rxi before ctrl", {15'd0, rx_irq}, 16'd1);
    do_write(6'h08, 16'h0020);
    chk("R8 rxi cleared by ctrl", {15'd0, rx_irq}, 16'd0);
    pulse_rdf();
    chk("R8 no rxi when disabled", {15'd0, rx_irq}, 16'd0);

    // R7 break set colliding with a clearing write
    @(negedge clk);
    brk_set = 1'b1; bus_we = 1'b1; bus_addr = 6'h10; bus_wdata = 16'h0000;
    @(negedge clk);
    brk_set = 1'b0; bus_we = 1'b0;
    do_read(6'h10);
    chk("R7 brk wins over clear", rd_val & 16'h0013, 16'h0010);

    // R9 receive data and count
    rx_data_in = 8'hC3; rx_count_in = 5'd5;
    do_read(6'h14);
    chk("R9 rx data", rd_val, 16'h00C3);
    chk("R9 pop", {15'd0, rd_pop}, 16'd1);
    do_read(6'h1C);
    chk("R9 rx count", rd_val, 16'h0005);
    chk("R9 no pop on count", {15'd0, rd_pop}, 16'd0);

    // R1 reset in mid run
    do_write(6'h08, 16'h00C0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 txi after reset", {15'd0, tx_irq}, 16'd0);
    do_read(6'h10);
    chk("R1 status after reset", rd_val, 16'h0060);
    do_read(6'h08);
    chk("R1 control after reset", rd_val, 16'h0020);

    finish_run();
  end
endmodule